// File: doc/BRIEF.md
# Pointer-Chasing Wakeup Engine

This block serves one bank of a RAM-based instruction window. It wakes consumers by walking a linked list instead of broadcasting a result tag. A produced value arrives as a pair: a pointer to the first operand slot that wants it, plus the value itself. The engine visits the slots one per cycle. At each slot it writes the value into the slot, and it sends the owning instruction to issue when that instruction's other source operand is already present. It then follows that slot's own forward pointer to the next consumer.

Pairs that arrive while the engine is busy wait in a five-entry pending queue. When a chain steps into an entry that belongs to another bank, the pair goes into a two-entry hand-off queue bound for the crossbar, and the engine frees itself for new work.

The operand RAM of the bank is a small stub inside the block. It has a dispatch write port and a probe read port. The issue arbiter and the crossbar are the environment: a grant input, and a ready input on the hand-off queue. The engine raises a stall flag whenever it holds a pointer it cannot advance. Deadlock recovery can build on that flag.

Top module: `pwe_engine`

## Requirements
- R1: A pointer is `{entry index, slot code}`, with the slot code in the low 2 bits. Code 0 is source 1, code 1 is source 2, code 2 is the destination, and code 3 is handled as the destination. The bank number is the low BANK_W bits of the entry index, and the local row is the remaining high bits.
- R2: When no pointer is held, the engine takes the head of the pending queue. Pairs are served in arrival order. With no held pointer, an empty pending queue and no incoming pair, the engine issues nothing, writes nothing and is not stalled.
- R3: When the visited slot is source 1 or source 2 and the other source of that entry is present, issue_valid is raised with the entry's opcode and global index. issue_a is source 1 and issue_b is source 2, one of them being the chain value. A destination slot, or an absent other operand, raises no issue.
- R4: If issue is requested and issue_grant is low, the engine keeps the same pointer, does not write the slot, and requests again on the next cycle.
- R5: A step that succeeds writes the chain value into the visited slot and marks that slot present. It then loads the next pointer from that slot's forward pointer field, and a cleared pointer-valid bit ends the chain.
- R6: If the next pointer is valid and names another bank, the pointer and value are pushed into the hand-off queue, and the held pointer is cleared.
- R7: The engine visits at most one slot per cycle. A chain of N local slots takes N consecutive cycles when every issue is granted.
- R8: The pending queue holds five pairs, and in_ready is low while it is full. The hand-off queue holds two pairs and presents them in order on xfer_valid, xfer_ptr and xfer_val.
- R9: With no held pointer and an empty pending queue, an incoming pair is worked on in the same cycle it is presented.
- R10: stalled is high in every cycle where the engine has a pointer it cannot advance. This covers a denied issue and a full hand-off queue with a remote next pointer. Such a pointer is kept and not dropped.
- R11: After reset, every slot is absent and every forward pointer is invalid. No issue or hand-off is presented, stalled is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming pointer/value pair valid |
| in_ptr | input | ENTRY_W+2 | Incoming pointer (entry index, slot code) |
| in_val | input | DATA_W | Incoming value |
| in_ready | output | 1 | Pair accepted (pending queue not full) |
| disp_we | input | 1 | Dispatch write of one slot |
| disp_lidx | input | ENTRY_W-BANK_W | Local row for dispatch write |
| disp_slot | input | 2 | Slot code for dispatch write |
| disp_val | input | DATA_W | Operand value written |
| disp_full | input | 1 | Operand present bit written |
| disp_ptr | input | ENTRY_W+2 | Forward pointer written |
| disp_ptr_v | input | 1 | Forward pointer valid bit written |
| disp_opc | input | OPC_W | Opcode written for the row |
| probe_lidx | input | ENTRY_W-BANK_W | Local row for probe read |
| probe_slot | input | 2 | Slot code for probe read |
| probe_val | output | DATA_W | Value of probed slot |
| probe_full | output | 1 | Present bit of probed slot |
| issue_valid | output | 1 | Issue request |
| issue_grant | input | 1 | Arbiter grant |
| issue_opc | output | OPC_W | Opcode of issued entry |
| issue_idx | output | ENTRY_W | Global index of issued entry |
| issue_a | output | DATA_W | Source 1 operand |
| issue_b | output | DATA_W | Source 2 operand |
| xfer_valid | output | 1 | Hand-off queue head valid |
| xfer_ready | input | 1 | Crossbar takes the head |
| xfer_ptr | output | ENTRY_W+2 | Remote pointer at head |
| xfer_val | output | DATA_W | Value at head |
| stalled | output | 1 | Held pointer cannot advance |

## Verification
The bench sweeps every slot code against both states of the other operand. A design that issued from destination slots, issued without the partner operand, or swapped the operand order would show up here. It walks a four-slot chain that mixes issuing and non-issuing stops, which exposes a skipped link or a second step in one cycle. It holds the grant low to show that the slot stays unwritten and the request repeats. A design that wrote before the grant or lost the pointer would double-issue or drop a consumer. It fills the pending queue to its limit and checks that in_ready drops and that service is in FIFO order. Finally it backs up the hand-off queue: a design that dropped the third remote pair or overwrote the slot early would give a wrong hand-off sequence or a wrong probed value.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  localparam int SLOT_W = 2;
  localparam int NSLOT  = 3;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_SRC1 = 2'd0,
    SLOT_SRC2 = 2'd1,
    SLOT_DST  = 2'd2,
    SLOT_RSVD = 2'd3
  } slot_e;

  // true when the slot code names a source operand
  function automatic logic slot_is_src(input logic [SLOT_W-1:0] s);
    return (s == SLOT_SRC1) || (s == SLOT_SRC2);
  endfunction

  // storage row of a slot code; the reserved code lands on the destination row
  function automatic logic [SLOT_W-1:0] slot_row(input logic [SLOT_W-1:0] s);
    return (s == SLOT_RSVD) ? SLOT_DST : s;
  endfunction

  // the partner source operand of a slot
  function automatic logic [SLOT_W-1:0] slot_other(input logic [SLOT_W-1:0] s);
    return (s == SLOT_SRC1) ? SLOT_SRC2 : SLOT_SRC1;
  endfunction
endpackage

// File: rtl/pwe_fifo.sv
module pwe_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wrap_inc(wr_q);
      if (do_pop)  rd_q <= wrap_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R8
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R8
endmodule

// File: rtl/pwe_bank_ram.sv
module pwe_bank_ram
  import pwe_pkg::*;
#(
  parameter int LIDX_W = 3,
  parameter int DATA_W = 16,
  parameter int OPC_W  = 6,
  parameter int PTR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  // walker read
  input  logic [LIDX_W-1:0] w_lidx,
  input  logic [SLOT_W-1:0] w_slot,
  output logic [OPC_W-1:0]  w_opc,
  output logic [DATA_W-1:0] w_oval,
  output logic              w_ofull,
  output logic [PTR_W-1:0]  w_nptr,
  output logic              w_nptr_v,
  // walker write
  input  logic              ww_en,
  input  logic [LIDX_W-1:0] ww_lidx,
  input  logic [SLOT_W-1:0] ww_slot,
  input  logic [DATA_W-1:0] ww_val,
  // dispatch write
  input  logic              d_we,
  input  logic [LIDX_W-1:0] d_lidx,
  input  logic [SLOT_W-1:0] d_slot,
  input  logic [DATA_W-1:0] d_val,
  input  logic              d_full,
  input  logic [PTR_W-1:0]  d_ptr,
  input  logic              d_ptr_v,
  input  logic [OPC_W-1:0]  d_opc,
  // probe read
  input  logic [LIDX_W-1:0] p_lidx,
  input  logic [SLOT_W-1:0] p_slot,
  output logic [DATA_W-1:0] p_val,
  output logic              p_full
);
  localparam int NENT = 1 << LIDX_W;

  logic [OPC_W-1:0] opc_q [NENT];
  logic [SLOT_W-1:0] w_row, w_orow, ww_row, d_row, p_row;

  logic [DATA_W-1:0] row_val   [NSLOT][NENT];
  logic [NENT-1:0]   row_full  [NSLOT];
  logic [PTR_W-1:0]  row_ptr   [NSLOT][NENT];
  logic [NENT-1:0]   row_ptr_v [NSLOT];

  assign w_row  = slot_row(w_slot);
  assign w_orow = slot_other(w_slot);
  assign ww_row = slot_row(ww_slot);
  assign d_row  = slot_row(d_slot);
  assign p_row  = slot_row(p_slot);

  // one storage row per operand slot
  for (genvar s = 0; s < NSLOT; s++) begin : g_row
    logic ww_hit, d_hit;
    assign ww_hit = ww_en && (ww_row == SLOT_W'(s));
    assign d_hit  = d_we  && (d_row  == SLOT_W'(s));

    always_ff @(posedge clk) begin
      if (ww_hit) row_val[s][ww_lidx] <= ww_val;
      if (d_hit) begin
        row_val[s][d_lidx] <= d_val;
        row_ptr[s][d_lidx] <= d_ptr;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        row_full[s]  <= '0;
        row_ptr_v[s] <= '0;
      end else begin
        if (ww_hit) row_full[s][ww_lidx] <= 1'b1;
        if (d_hit) begin
          row_full[s][d_lidx]  <= d_full;
          row_ptr_v[s][d_lidx] <= d_ptr_v;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (d_we) opc_q[d_lidx] <= d_opc;
  end

  assign w_opc    = opc_q[w_lidx];
  assign w_oval   = row_val[w_orow][w_lidx];
  assign w_ofull  = row_full[w_orow][w_lidx];
  assign w_nptr   = row_ptr[w_row][w_lidx];
  assign w_nptr_v = row_ptr_v[w_row][w_lidx];
  assign p_val    = row_val[p_row][p_lidx];
  assign p_full   = row_full[p_row][p_lidx];
endmodule

// File: rtl/pwe_walker.sv
module pwe_walker
  import pwe_pkg::*;
#(
  parameter int ENTRY_W = 5,
  parameter int BANK_W  = 2,
  parameter int BANK_ID = 1,
  parameter int DATA_W  = 16,
  parameter int OPC_W   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  // pending queue head
  input  logic                      pend_empty,
  input  logic [ENTRY_W+SLOT_W-1:0] pend_ptr,
  input  logic [DATA_W-1:0]         pend_val,
  output logic                      pend_pop,
  // interconnect arrival
  input  logic                      in_valid,
  input  logic [ENTRY_W+SLOT_W-1:0] in_ptr,
  input  logic [DATA_W-1:0]         in_val,
  output logic                      in_take,
  // RAM read
  output logic [ENTRY_W-BANK_W-1:0] rd_lidx,
  output logic [SLOT_W-1:0]         rd_slot,
  input  logic [OPC_W-1:0]          rd_opc,
  input  logic [DATA_W-1:0]         rd_oval,
  input  logic                      rd_ofull,
  input  logic [ENTRY_W+SLOT_W-1:0] rd_nptr,
  input  logic                      rd_nptr_v,
  // RAM write
  output logic                      wr_en,
  output logic [ENTRY_W-BANK_W-1:0] wr_lidx,
  output logic [SLOT_W-1:0]         wr_slot,
  output logic [DATA_W-1:0]         wr_val,
  // issue
  output logic                      issue_valid,
  input  logic                      issue_grant,
  output logic [OPC_W-1:0]          issue_opc,
  output logic [ENTRY_W-1:0]        issue_idx,
  output logic [DATA_W-1:0]         issue_a,
  output logic [DATA_W-1:0]         issue_b,
  // hand-off
  input  logic                      xfer_full,
  output logic                      xfer_push,
  output logic [ENTRY_W+SLOT_W-1:0] xfer_ptr,
  output logic [DATA_W-1:0]         xfer_val,
  output logic                      stalled
);
  localparam int PTR_W  = ENTRY_W + SLOT_W;
  localparam int LIDX_W = ENTRY_W - BANK_W;

  function automatic logic [BANK_W-1:0] bank_of(input logic [PTR_W-1:0] p);
    return p[SLOT_W +: BANK_W];
  endfunction
  function automatic logic [LIDX_W-1:0] row_of(input logic [PTR_W-1:0] p);
    return p[PTR_W-1 -: LIDX_W];
  endfunction

  logic              nv_q;
  logic [PTR_W-1:0]  np_q;
  logic [DATA_W-1:0] val_q;

  logic              take_pend, cur_v, need_issue, remote, xfer_block, advance;
  logic [PTR_W-1:0]  cur_p;
  logic [DATA_W-1:0] cur_d;
  logic [SLOT_W-1:0] cur_slot;

  // choose the pointer worked on this cycle
  always_comb begin
    take_pend = !nv_q && !pend_empty;
    in_take   = !nv_q && pend_empty && in_valid;
    cur_v     = nv_q || take_pend || in_take;
    if (nv_q) begin
      cur_p = np_q;
      cur_d = val_q;
    end else if (take_pend) begin
      cur_p = pend_ptr;
      cur_d = pend_val;
    end else begin
      cur_p = in_ptr;
      cur_d = in_val;
    end
  end

  assign cur_slot = cur_p[SLOT_W-1:0];
  assign pend_pop = take_pend;
  assign rd_lidx  = row_of(cur_p);
  assign rd_slot  = cur_slot;

  // step decision
  always_comb begin
    need_issue = cur_v && slot_is_src(cur_slot) && rd_ofull;
    remote     = rd_nptr_v && (bank_of(rd_nptr) != BANK_W'(BANK_ID));
    xfer_block = cur_v && remote && xfer_full;
    advance    = cur_v && !xfer_block && (!need_issue || issue_grant);
  end

  assign issue_valid = need_issue && !xfer_block;
  assign issue_opc   = rd_opc;
  assign issue_idx   = cur_p[PTR_W-1:SLOT_W];
  assign issue_a     = (cur_slot == SLOT_SRC1) ? cur_d : rd_oval;
  assign issue_b     = (cur_slot == SLOT_SRC1) ? rd_oval : cur_d;

  assign wr_en   = advance;
  assign wr_lidx = row_of(cur_p);
  assign wr_slot = cur_slot;
  assign wr_val  = cur_d;

  assign xfer_push = advance && remote;
  assign xfer_ptr  = rd_nptr;
  assign xfer_val  = cur_d;
  assign stalled   = cur_v && !advance;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nv_q  <= 1'b0;
      np_q  <= '0;
      val_q <= '0;
    end else if (advance) begin
      nv_q  <= rd_nptr_v && !remote;
      np_q  <= rd_nptr;
      val_q <= cur_d;
    end else if (cur_v) begin
      nv_q  <= 1'b1;
      np_q  <= cur_p;
      val_q <= cur_d;
    end
  end

  AST_HOLD_ON_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_grant) |=> (nv_q && np_q == $past(cur_p))); // R4
  AST_STALL_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> nv_q); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!nv_q && pend_empty && !in_valid) |-> (!issue_valid && !wr_en && !stalled && !xfer_push)); // R2
  AST_XFER_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_push |-> (bank_of(xfer_ptr) != BANK_W'(BANK_ID))); // R6
  AST_ISSUE_HAS_PARTNER: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (rd_ofull && cur_slot != SLOT_DST && cur_slot != SLOT_RSVD)); // R3
endmodule

// File: rtl/pwe_engine.sv
module pwe_engine
  import pwe_pkg::*;
#(
  parameter int ENTRY_W    = 5,
  parameter int BANK_W     = 2,
  parameter int BANK_ID    = 1,
  parameter int DATA_W     = 16,
  parameter int OPC_W      = 6,
  parameter int PEND_DEPTH = 5,
  parameter int XFER_DEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [ENTRY_W+1:0]        in_ptr,
  input  logic [DATA_W-1:0]         in_val,
  output logic                      in_ready,
  input  logic                      disp_we,
  input  logic [ENTRY_W-BANK_W-1:0] disp_lidx,
  input  logic [1:0]                disp_slot,
  input  logic [DATA_W-1:0]         disp_val,
  input  logic                      disp_full,
  input  logic [ENTRY_W+1:0]        disp_ptr,
  input  logic                      disp_ptr_v,
  input  logic [OPC_W-1:0]          disp_opc,
  input  logic [ENTRY_W-BANK_W-1:0] probe_lidx,
  input  logic [1:0]                probe_slot,
  output logic [DATA_W-1:0]         probe_val,
  output logic                      probe_full,
  output logic                      issue_valid,
  input  logic                      issue_grant,
  output logic [OPC_W-1:0]          issue_opc,
  output logic [ENTRY_W-1:0]        issue_idx,
  output logic [DATA_W-1:0]         issue_a,
  output logic [DATA_W-1:0]         issue_b,
  output logic                      xfer_valid,
  input  logic                      xfer_ready,
  output logic [ENTRY_W+1:0]        xfer_ptr,
  output logic [DATA_W-1:0]         xfer_val,
  output logic                      stalled
);
  localparam int PTR_W  = ENTRY_W + SLOT_W;
  localparam int LIDX_W = ENTRY_W - BANK_W;
  localparam int PAIR_W = PTR_W + DATA_W;

  logic              pend_empty, pend_full, pend_pop, pend_push, in_take;
  logic [PAIR_W-1:0] pend_head;
  logic              xq_empty, xq_full, xq_push;
  logic [PTR_W-1:0]  xq_in_ptr;
  logic [DATA_W-1:0] xq_in_val;
  logic [PAIR_W-1:0] xq_head;

  logic [LIDX_W-1:0] rd_lidx, wr_lidx;
  logic [SLOT_W-1:0] rd_slot, wr_slot;
  logic [OPC_W-1:0]  rd_opc;
  logic [DATA_W-1:0] rd_oval, wr_val;
  logic              rd_ofull, rd_nptr_v, wr_en;
  logic [PTR_W-1:0]  rd_nptr;

  assign in_ready  = !pend_full;
  assign pend_push = in_valid && !pend_full && !in_take;

  pwe_fifo #(.W(PAIR_W), .DEPTH(PEND_DEPTH)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .push(pend_push), .din({in_ptr, in_val}),
    .pop(pend_pop), .dout(pend_head),
    .empty(pend_empty), .full(pend_full)
  );

  pwe_fifo #(.W(PAIR_W), .DEPTH(XFER_DEPTH)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .push(xq_push), .din({xq_in_ptr, xq_in_val}),
    .pop(xfer_valid && xfer_ready), .dout(xq_head),
    .empty(xq_empty), .full(xq_full)
  );

  assign xfer_valid = !xq_empty;
  assign xfer_ptr   = xq_head[PAIR_W-1 -: PTR_W];
  assign xfer_val   = xq_head[DATA_W-1:0];

  pwe_bank_ram #(.LIDX_W(LIDX_W), .DATA_W(DATA_W), .OPC_W(OPC_W), .PTR_W(PTR_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .w_lidx(rd_lidx), .w_slot(rd_slot), .w_opc(rd_opc), .w_oval(rd_oval),
    .w_ofull(rd_ofull), .w_nptr(rd_nptr), .w_nptr_v(rd_nptr_v),
    .ww_en(wr_en), .ww_lidx(wr_lidx), .ww_slot(wr_slot), .ww_val(wr_val),
    .d_we(disp_we), .d_lidx(disp_lidx), .d_slot(disp_slot), .d_val(disp_val),
    .d_full(disp_full), .d_ptr(disp_ptr), .d_ptr_v(disp_ptr_v), .d_opc(disp_opc),
    .p_lidx(probe_lidx), .p_slot(probe_slot), .p_val(probe_val), .p_full(probe_full)
  );

  pwe_walker #(.ENTRY_W(ENTRY_W), .BANK_W(BANK_W), .BANK_ID(BANK_ID),
               .DATA_W(DATA_W), .OPC_W(OPC_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .pend_empty(pend_empty), .pend_ptr(pend_head[PAIR_W-1 -: PTR_W]),
    .pend_val(pend_head[DATA_W-1:0]), .pend_pop(pend_pop),
    .in_valid(in_valid), .in_ptr(in_ptr), .in_val(in_val), .in_take(in_take),
    .rd_lidx(rd_lidx), .rd_slot(rd_slot), .rd_opc(rd_opc), .rd_oval(rd_oval),
    .rd_ofull(rd_ofull), .rd_nptr(rd_nptr), .rd_nptr_v(rd_nptr_v),
    .wr_en(wr_en), .wr_lidx(wr_lidx), .wr_slot(wr_slot), .wr_val(wr_val),
    .issue_valid(issue_valid), .issue_grant(issue_grant), .issue_opc(issue_opc),
    .issue_idx(issue_idx), .issue_a(issue_a), .issue_b(issue_b),
    .xfer_full(xq_full), .xfer_push(xq_push), .xfer_ptr(xq_in_ptr),
    .xfer_val(xq_in_val), .stalled(stalled)
  );

  AST_PEND_ORDER_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    in_take |-> pend_empty); // R9
endmodule

// File: tb/pwe_engine_tb_top.sv
module pwe_engine_tb_top;
  localparam int ENTRY_W = 5;
  localparam int BANK_W  = 2;
  localparam int DATA_W  = 16;
  localparam int OPC_W   = 6;
  localparam int PTR_W   = ENTRY_W + 2;
  localparam int LIDX_W  = ENTRY_W - BANK_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [PTR_W-1:0] in_ptr = '0;
  logic [DATA_W-1:0] in_val = '0;
  logic in_ready;
  logic disp_we = 1'b0;
  logic [LIDX_W-1:0] disp_lidx = '0;
  logic [1:0] disp_slot = '0;
  logic [DATA_W-1:0] disp_val = '0;
  logic disp_full = 1'b0;
  logic [PTR_W-1:0] disp_ptr = '0;
  logic disp_ptr_v = 1'b0;
  logic [OPC_W-1:0] disp_opc = '0;
  logic [LIDX_W-1:0] probe_lidx = '0;
  logic [1:0] probe_slot = '0;
  logic [DATA_W-1:0] probe_val;
  logic probe_full;
  logic issue_valid;
  logic issue_grant = 1'b1;
  logic [OPC_W-1:0] issue_opc;
  logic [ENTRY_W-1:0] issue_idx;
  logic [DATA_W-1:0] issue_a, issue_b;
  logic xfer_valid;
  logic xfer_ready = 1'b0;
  logic [PTR_W-1:0] xfer_ptr;
  logic [DATA_W-1:0] xfer_val;
  logic stalled;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwe_engine dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ptr(in_ptr), .in_val(in_val),
    .in_ready(in_ready), .disp_we(disp_we), .disp_lidx(disp_lidx), .disp_slot(disp_slot),
    .disp_val(disp_val), .disp_full(disp_full), .disp_ptr(disp_ptr), .disp_ptr_v(disp_ptr_v),
    .disp_opc(disp_opc), .probe_lidx(probe_lidx), .probe_slot(probe_slot),
    .probe_val(probe_val), .probe_full(probe_full), .issue_valid(issue_valid),
    .issue_grant(issue_grant), .issue_opc(issue_opc), .issue_idx(issue_idx),
    .issue_a(issue_a), .issue_b(issue_b), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_ptr(xfer_ptr), .xfer_val(xfer_val), .stalled(stalled)
  );

  // R1: global index = {local row, bank 1}, pointer = {index, slot}
  function automatic logic [ENTRY_W-1:0] gidx(input int row);
    return {3'(row), 2'b01};
  endfunction
  function automatic logic [PTR_W-1:0] mkp(input int row, input int slot);
    return {gidx(row), 2'(slot)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic dw(input int row, input int slot, input logic [DATA_W-1:0] v,
                    input logic f, input logic pv, input logic [PTR_W-1:0] p,
                    input logic [OPC_W-1:0] opc);
    tick();
    disp_we = 1'b1; disp_lidx = 3'(row); disp_slot = 2'(slot); disp_val = v;
    disp_full = f; disp_ptr_v = pv; disp_ptr = p; disp_opc = opc;
    @(posedge clk);
    #1 disp_we = 1'b0;
  endtask

  task automatic probe(input int row, input int slot);
    probe_lidx = 3'(row); probe_slot = 2'(slot);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v0, v1, vv;
    logic exp_iss;
    logic [PTR_W-1:0] rp1, rp2;
    repeat (3) @(posedge clk);
    tick();
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 issue_valid", 32'(issue_valid), 0);
    chk("R11 xfer_valid", 32'(xfer_valid), 0);
    chk("R11 stalled", 32'(stalled), 0);
    chk("R11 in_ready", 32'(in_ready), 1);
    probe(3, 2);
    chk("R11 slot absent", 32'(probe_full), 0);

    // R3/R5 sweep over slot code and partner presence; R9 same-cycle
    for (int s = 0; s < 3; s++) begin
      for (int f = 0; f < 2; f++) begin
        v0 = 16'h0A00 + 16'(s * 2 + f);
        v1 = 16'h0B00 + 16'(s * 2 + f);
        vv = 16'h0C00 + 16'(s * 2 + f);
        dw(2, 0, v0, (s == 0) ? 1'b0 : 1'(f), 1'b0, '0, 6'(s * 2 + f + 1));
        dw(2, 1, v1, (s == 1) ? 1'b0 : 1'(f), 1'b0, '0, 6'(s * 2 + f + 1));
        dw(2, 2, 16'h0, 1'b0, 1'b0, '0, 6'(s * 2 + f + 1));
        tick();
        in_valid = 1'b1; in_ptr = mkp(2, s); in_val = vv;
        #1;
        exp_iss = (s != 2) && (f == 1);
        chk("R3 issue on slot/partner", 32'(issue_valid), 32'(exp_iss));
        if (exp_iss) begin
          chk("R3 operand a", 32'(issue_a), (s == 0) ? 32'(vv) : 32'(v0));
          chk("R3 operand b", 32'(issue_b), (s == 0) ? 32'(v1) : 32'(vv));
          chk("R3 opcode", 32'(issue_opc), 32'(s * 2 + f + 1));
          chk("R1 issue index", 32'(issue_idx), 32'(gidx(2)));
        end
        tick();
        in_valid = 1'b0;
        #1;
        probe(2, s);
        chk("R5 slot written", 32'(probe_val), 32'(vv));
        chk("R5 slot present", 32'(probe_full), 1);
        chk("R2 idle after chain end", 32'(issue_valid | stalled), 0);
      end
    end

    // R7/R5 chain: dst(0) -> src1(1) -> src2(2) -> src1(3) -> end
    dw(0, 2, 16'h0, 1'b0, 1'b1, mkp(1, 0), 6'd20);
    dw(1, 1, 16'h0007, 1'b1, 1'b0, '0, 6'd21);
    dw(1, 0, 16'h0, 1'b0, 1'b1, mkp(2, 1), 6'd21);
    dw(2, 0, 16'h0, 1'b0, 1'b0, '0, 6'd22);
    dw(2, 1, 16'h0, 1'b0, 1'b1, mkp(3, 0), 6'd22);
    dw(3, 1, 16'h0009, 1'b1, 1'b0, '0, 6'd23);
    dw(3, 0, 16'h0, 1'b0, 1'b0, '0, 6'd23);
    tick();
    in_valid = 1'b1; in_ptr = mkp(0, 2); in_val = 16'h0099;
    #1;
    chk("R3 destination no issue", 32'(issue_valid), 0);
    tick();
    in_valid = 1'b0;
    #1;
    chk("R7 step1 issue", 32'(issue_valid), 1);
    chk("R7 step1 a", 32'(issue_a), 32'h99);
    chk("R7 step1 b", 32'(issue_b), 32'h7);
    chk("R7 step1 opc", 32'(issue_opc), 21);
    tick();
    chk("R7 step2 partner absent", 32'(issue_valid), 0);
    chk("R7 step2 not stalled", 32'(stalled), 0);
    tick();
    chk("R7 step3 issue", 32'(issue_valid), 1);
    chk("R7 step3 idx", 32'(issue_idx), 32'(gidx(3)));
    chk("R7 step3 a", 32'(issue_a), 32'h99);
    chk("R7 step3 b", 32'(issue_b), 32'h9);
    tick();
    chk("R5 chain ends on invalid ptr", 32'(issue_valid | stalled), 0);
    probe(2, 1);
    chk("R5 middle slot value", 32'(probe_val), 32'h99);

    // R4 denied issue
    dw(4, 1, 16'h0044, 1'b1, 1'b0, '0, 6'd30);
    dw(4, 0, 16'h0, 1'b0, 1'b0, '0, 6'd30);
    tick();
    issue_grant = 1'b0;
    in_valid = 1'b1; in_ptr = mkp(4, 0); in_val = 16'h0055;
    #1;
    chk("R4 request shown", 32'(issue_valid), 1);
    chk("R10 stalled on deny", 32'(stalled), 1);
    for (int k = 0; k < 2; k++) begin
      tick();
      in_valid = 1'b0;
      #1;
      probe(4, 0);
      chk("R4 retry request", 32'(issue_valid), 1);
      chk("R4 retry a", 32'(issue_a), 32'h55);
      chk("R4 slot not written", 32'(probe_full), 0);
      chk("R10 still stalled", 32'(stalled), 1);
    end
    tick();
    issue_grant = 1'b1;
    #1;
    chk("R4 granted issue", 32'(issue_valid), 1);
    chk("R10 released", 32'(stalled), 0);
    tick();
    probe(4, 0);
    chk("R4 single issue", 32'(issue_valid), 0);
    chk("R4 slot written after grant", 32'(probe_full), 1);

    // R8/R2 pending queue fill and order
    dw(5, 1, 16'h0050, 1'b1, 1'b0, '0, 6'd40);
    dw(5, 0, 16'h0, 1'b0, 1'b0, '0, 6'd40);
    for (int k = 0; k < 5; k++) begin
      dw(k, 1, 16'h0060 + 16'(k), 1'b1, 1'b0, '0, 6'(k + 10));
      dw(k, 0, 16'h0, 1'b0, 1'b0, '0, 6'(k + 10));
    end
    tick();
    issue_grant = 1'b0;
    in_valid = 1'b1; in_ptr = mkp(5, 0); in_val = 16'h0055;
    #1;
    chk("R9 holder fast path", 32'(issue_valid), 1);
    for (int k = 0; k < 5; k++) begin
      tick();
      in_ptr = mkp(k, 0); in_val = 16'h0070 + 16'(k);
      #1;
      chk("R8 pending has room", 32'(in_ready), 1);
    end
    tick();
    in_ptr = mkp(6, 0); in_val = 16'h00FF;
    #1;
    chk("R8 pending full", 32'(in_ready), 0);
    tick();
    in_valid = 1'b0;
    issue_grant = 1'b1;
    #1;
    chk("R8 holder issues", 32'(issue_a), 32'h55);
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R2 pending served", 32'(issue_valid), 1);
      chk("R2 pending order a", 32'(issue_a), 32'h70 + 32'(k));
      chk("R2 pending order b", 32'(issue_b), 32'h60 + 32'(k));
    end
    tick();
    chk("R2 drained idle", 32'(issue_valid | stalled), 0);
    chk("R8 room again", 32'(in_ready), 1);

    // R6/R10 hand-off to other banks
    rp1 = {3'd2, 2'b10, 2'd0};
    rp2 = {3'd5, 2'b11, 2'd1};
    dw(6, 2, 16'h0, 1'b0, 1'b1, rp1, 6'd50);
    dw(7, 2, 16'h0, 1'b0, 1'b1, rp2, 6'd51);
    xfer_ready = 1'b0;
    tick();
    in_valid = 1'b1; in_ptr = mkp(6, 2); in_val = 16'h0011;
    #1;
    chk("R6 first push no stall", 32'(stalled), 0);
    tick();
    in_ptr = mkp(7, 2); in_val = 16'h0022;
    #1;
    chk("R6 head valid", 32'(xfer_valid), 1);
    chk("R6 head ptr", 32'(xfer_ptr), 32'(rp1));
    chk("R6 head val", 32'(xfer_val), 32'h11);
    tick();
    in_ptr = mkp(6, 2); in_val = 16'h0033;
    #1;
    chk("R10 hand-off full stalls", 32'(stalled), 1);
    tick();
    in_valid = 1'b0;
    #1;
    probe(6, 2);
    chk("R10 held and kept", 32'(stalled), 1);
    chk("R10 slot not overwritten", 32'(probe_val), 32'h11);
    xfer_ready = 1'b1;
    #1;
    chk("R8 order first", 32'(xfer_val), 32'h11);
    tick();
    chk("R8 order second", 32'(xfer_val), 32'h22);
    chk("R8 second ptr", 32'(xfer_ptr), 32'(rp2));
    chk("R10 advances with room", 32'(stalled), 0);
    tick();
    chk("R6 third pair", 32'(xfer_val), 32'h33);
    chk("R6 third ptr", 32'(xfer_ptr), 32'(rp1));
    chk("R6 next cleared", 32'(stalled | issue_valid), 0);
    tick();
    probe(6, 2);
    chk("R6 queue drained", 32'(xfer_valid), 0);
    chk("R5 slot final", 32'(probe_val), 32'h33);
    xfer_ready = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule